// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic logic unit with its operation decoder. A main controller supplies a 2-bit operation class. For arithmetic instructions, the 6-bit function field of the instruction word is also supplied. The decoder resolves these two inputs into a 3-bit unit select. The datapath then applies AND, OR, ADD, SUB or signed set-if-less-than to the two 32-bit operands.

Decoding happens in two levels. The memory-access class and the jump class force addition, and the branch-compare class forces subtraction. Only the arithmetic class consults the function field. The unit returns the result together with zero, signed-overflow and carry-out flags. The adder's carry-in is generated inside the unit and is raised whenever the operation needs a subtraction. The resolved select is also driven out, so the surrounding datapath can observe it.

Top module: `alu_unit`

## Requirements
- R1: The operation class sets the select directly for three of its four values: class 2'b00 (memory access) gives ADD (3'b010), class 2'b01 (branch compare) gives SUB (3'b110), and class 2'b11 (jump) gives ADD. In these classes the function field has no effect.
- R2: In class 2'b10 the function field picks the select: 6'h20 gives ADD, 6'h22 gives SUB, 6'h24 gives AND (3'b000), 6'h25 gives OR (3'b001) and 6'h2A gives SLT (3'b111). Every other function code gives ADD.
- R3: AND and OR return the bitwise AND and OR of the operands. For both, the overflow flag and the carry flag are 0.
- R4: ADD returns (a + b) mod 2^32. Carry-out is the carry leaving bit 31 of that sum.
- R5: SUB returns (a - b) mod 2^32, computed as a + ~b + 1. Carry-out is the carry leaving bit 31, so it is 1 exactly when a >= b as unsigned numbers.
- R6: The overflow flag shows signed two's-complement overflow, and only for ADD and SUB. It is 0 for AND, OR and SLT.
- R7: SLT returns 1 in bit 0 when a < b as signed numbers, and returns 0 in all other bits. The signed comparison is taken as the sign of the difference XOR subtraction overflow, so it stays correct when the difference overflows. Carry-out for SLT is the subtractor's carry.
- R8: The zero flag is 1 exactly when all 32 result bits are 0, whatever the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of an arithmetic instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| alu_sel_o | output | 3 | Resolved unit select |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow for ADD and SUB |
| carry_o | output | 1 | Carry leaving bit 31 of the adder |

## Verification
Three flags can assert in the same evaluation: zero, carry-out and overflow. For example, 0x80000000 + 0x80000000 wraps to zero, and a wrapping carry such as 0xFFFFFFFF + 1 raises zero and carry without overflow. Directed vectors provoke these collisions in ADD and SUB. Vectors such as 0x80000000 against 1 make SLT's difference overflow. A behavioural model built on wide integer arithmetic judges every output independently on each vector. Several thousand random operand and function pairs follow the directed vectors.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alu_sel_e;

  typedef enum logic [1:0] {
    CLS_MEM   = 2'b00,
    CLS_BEQ   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_JUMP  = 2'b11
  } op_class_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [1:0] op_class_i,
  input  logic [5:0] funct_i,
  output alu_sel_e   sel_o
);

  alu_sel_e fn_sel;

  // second level: function field, consulted only for arithmetic class
  always_comb begin
    unique case (funct_i)
      FN_ADD:  fn_sel = SEL_ADD;
      FN_SUB:  fn_sel = SEL_SUB;
      FN_AND:  fn_sel = SEL_AND;
      FN_OR:   fn_sel = SEL_OR;
      FN_SLT:  fn_sel = SEL_SLT;
      default: fn_sel = SEL_ADD;
    endcase
  end

  // first level: coarse class
  always_comb begin
    unique case (op_class_e'(op_class_i))
      CLS_BEQ:   sel_o = SEL_SUB;
      CLS_ARITH: sel_o = fn_sel;
      default:   sel_o = SEL_ADD;
    endcase
  end

  always_comb begin
    if (!$isunknown(op_class_i) && op_class_i != CLS_ARITH)
      p_class_forced_r1: assert (sel_o == SEL_ADD || sel_o == SEL_SUB);
    if (!$isunknown(sel_o))
      p_sel_legal_r2: assert (sel_o inside {SEL_AND, SEL_OR, SEL_ADD, SEL_SUB, SEL_SLT});
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int unsigned LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [LOW_W-1:0] low_sum;
  logic             c_into_msb;
  logic             msb_sum;

  // hidden carry-in doubles as the +1 of two's complement
  assign b_eff = sub_i ? ~b_i : b_i;

  assign {c_into_msb, low_sum} = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                               + {{LOW_W{1'b0}}, sub_i};
  assign {carry_o, msb_sum}    = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                               + {1'b0, c_into_msb};

  assign sum_o = {msb_sum, low_sum};
  assign ovf_o = c_into_msb ^ carry_o;

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  alu_sel_e         sel_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);

  logic             sub_mode;
  logic             use_adder;
  logic [WIDTH-1:0] sum;
  logic             add_carry;
  logic             add_ovf;
  logic             lt_signed;

  assign sub_mode  = (sel_i == SEL_SUB) || (sel_i == SEL_SLT);
  assign use_adder = sub_mode || (sel_i == SEL_ADD);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_mode),
    .sum_o  (sum),
    .carry_o(add_carry),
    .ovf_o  (add_ovf)
  );

  assign lt_signed = sum[WIDTH-1] ^ add_ovf;

  always_comb begin
    result_o = '0;
    unique case (sel_i)
      SEL_AND: result_o = a_i & b_i;
      SEL_OR:  result_o = a_i | b_i;
      SEL_ADD,
      SEL_SUB: result_o = sum;
      SEL_SLT: result_o[0] = lt_signed;
      default: result_o = '0;
    endcase
  end

  assign zero_o  = ~|result_o;
  assign ovf_o   = add_ovf & (sel_i == SEL_ADD || sel_i == SEL_SUB);
  assign carry_o = add_carry & use_adder;

  always_comb begin
    if (!$isunknown(sel_i) && (sel_i == SEL_AND || sel_i == SEL_OR))
      p_logic_flags_clear_r3: assert (!ovf_o && !carry_o);
    if (!$isunknown(sel_i) && sel_i == SEL_SLT)
      p_slt_no_overflow_r6: assert (!ovf_o);
    if (!$isunknown({sel_i, result_o}) && sel_i == SEL_SLT)
      p_slt_upper_clear_r7: assert (result_o[WIDTH-1:1] == '0);
    if (!$isunknown({sel_i, a_i, b_i}) && sel_i == SEL_SUB && a_i == b_i)
      p_sub_equal_r5: assert (zero_o && carry_o && !ovf_o);
  end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       op_class_i,
  input  logic [5:0]       funct_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [2:0]       alu_sel_o,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             carry_o
);

  alu_sel_e sel;

  alu_op_decode u_decode (
    .op_class_i(op_class_i),
    .funct_i   (funct_i),
    .sel_o     (sel)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .sel_i   (sel),
    .a_i     (a_i),
    .b_i     (b_i),
    .result_o(result_o),
    .zero_o  (zero_o),
    .ovf_o   (ovf_o),
    .carry_o (carry_o)
  );

  assign alu_sel_o = sel;

  always_comb begin
    if (!$isunknown(op_class_i) && op_class_i == CLS_BEQ)
      p_beq_sub_r1: assert (alu_sel_o == SEL_SUB);
    if (!$isunknown(result_o))
      p_zero_flag_r8: assert (zero_o == (result_o == '0));
  end

endmodule

// File: tb/tb_alu_unit.sv
`timescale 1ns/1ps
module tb_alu_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] a, b;
  logic [2:0]  alu_sel;
  logic [31:0] result;
  logic        zero, ovf, carry;

  int n_vec = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_unit dut (
    .op_class_i(op_class), .funct_i(funct), .a_i(a), .b_i(b),
    .alu_sel_o(alu_sel), .result_o(result), .zero_o(zero),
    .ovf_o(ovf), .carry_o(carry)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  function automatic logic [2:0] ref_sel(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b01) return 3'b110;
    if (c != 2'b10) return 3'b010;
    case (f)
      6'h20: return 3'b010;
      6'h22: return 3'b110;
      6'h24: return 3'b000;
      6'h25: return 3'b001;
      6'h2A: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: cls=%0d fn=%h a=%h b=%h actual=%h expected=%h",
               tag, what, op_class, funct, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [2:0]  es;
    logic [32:0] wide;
    logic [31:0] er;
    logic        ec, eo;
    string       tg;
    @(posedge clk);
    op_class = c; funct = f; a = x; b = y;
    es = ref_sel(c, f);
    ec = 1'b0; eo = 1'b0;
    case (es)
      3'b000: begin er = x & y; tg = "R3"; end
      3'b001: begin er = x | y; tg = "R3"; end
      3'b010: begin
        wide = {1'b0, x} + {1'b0, y}; er = wide[31:0]; ec = wide[32];
        eo = (x[31] == y[31]) && (er[31] != x[31]); tg = "R4";
      end
      3'b110: begin
        wide = {1'b0, x} + {1'b0, ~y} + 33'd1; er = wide[31:0]; ec = wide[32];
        eo = (x[31] != y[31]) && (er[31] != x[31]); tg = "R5";
      end
      default: begin
        wide = {1'b0, x} + {1'b0, ~y} + 33'd1; ec = wide[32];
        er = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0; tg = "R7";
      end
    endcase
    @(negedge clk);
    cmp((c == 2'b10) ? "R2" : "R1", "select", longint'(alu_sel), longint'(es));
    cmp(tg, "result", longint'(result), longint'(er));
    cmp(tg, "carry", longint'(carry), longint'(ec));
    cmp("R6", "overflow", longint'(ovf), longint'(eo));
    cmp("R8", "zero", longint'(zero), longint'(er == 32'd0));
  endtask

  initial begin
    op_class = 2'b00; funct = 6'h00; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // quiescent inputs: add of zeros, zero flag up
    @(negedge clk);
    cmp("R8", "idle zero", longint'(zero), 1);
    cmp("R1", "idle select", longint'(alu_sel), 2);
    // R1: forced classes ignore function field
    apply(2'b00, 6'h24, 32'd1000, 32'd32);
    apply(2'b01, 6'h25, 32'd5, 32'd5);
    apply(2'b11, 6'h2A, 32'h1234_0000, 32'h0000_5678);
    apply(2'b01, 6'h20, 32'd3, 32'd7);
    // R2: function mapping and defaults
    apply(2'b10, 6'h20, 32'd10, 32'd20);
    apply(2'b10, 6'h22, 32'd10, 32'd20);
    apply(2'b10, 6'h24, 32'hF0F0_F0F0, 32'hFF00_FF00);
    apply(2'b10, 6'h25, 32'hF0F0_F0F0, 32'h0F00_0F00);
    apply(2'b10, 6'h2A, 32'd1, 32'd2);
    apply(2'b10, 6'h00, 32'd9, 32'd9);
    apply(2'b10, 6'h3F, 32'hFFFF_FFFF, 32'd2);
    apply(2'b10, 6'h26, 32'd1, 32'd1);
    // R3: logic with zero result
    apply(2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555);
    apply(2'b10, 6'h25, 32'd0, 32'd0);
    // R4/R6/R8: flag collisions
    apply(2'b10, 6'h20, 32'h8000_0000, 32'h8000_0000);
    apply(2'b10, 6'h20, 32'hFFFF_FFFF, 32'd1);
    apply(2'b10, 6'h20, 32'h7FFF_FFFF, 32'd1);
    // R5: subtraction corners
    apply(2'b10, 6'h22, 32'd0, 32'd1);
    apply(2'b10, 6'h22, 32'h8000_0000, 32'd1);
    apply(2'b10, 6'h22, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(2'b10, 6'h22, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    // R7: signed compare incl. overflowing difference
    apply(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd1);
    apply(2'b10, 6'h2A, 32'd1, 32'hFFFF_FFFF);
    apply(2'b10, 6'h2A, 32'h8000_0000, 32'd1);
    apply(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(2'b10, 6'h2A, 32'd4, 32'd4);
    // random sweep across all classes and function codes
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] fr;
      fr = (i % 3 == 0) ? 6'($urandom) : 6'(ref_sel_pick(i));
      apply(2'($urandom), fr, $urandom, (i % 7 == 0) ? 32'd0 : $urandom);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  function automatic int ref_sel_pick(input int i);
    case (i % 5)
      0: return 32'h20;
      1: return 32'h22;
      2: return 32'h24;
      3: return 32'h25;
      default: return 32'h2A;
    endcase
  endfunction

endmodule